// File: doc/BRIEF.md
# Bit-Serial HDLC Receiver with Repeat Suppression

This block takes the serial data-link bit stream recovered by a framer and turns it into messages a host can read. It finds opening and closing flags, removes the zeros the transmitter stuffed, packs bits into bytes (least significant bit first), and can check the 16-bit frame check sequence. It also watches the raw stream for bit-oriented codewords and turns a confirmed codeword into a one-byte message.

Completed messages land in a holding buffer that the host reads through a byte-wide read port. When repeat suppression is switched on, a new message whose length and bytes equal what the buffer already holds is dropped silently. The host is then told only when the content has changed. Status flags stay set until the host strobes an acknowledge.

Top module: `hdlc_dup_rx`

## Requirements
- R1: A frame sits between two flags of value 0x7E. Its bits are packed into bytes least significant bit first. A delivered frame is readable at `rd_data` for `rd_addr` 0 to `msg_len`-1, and `msg_ready` goes to 1.
- R2: Inside a frame, a 0 that follows five consecutive 1s is removed from the data. Payload bytes such as 0xFF and 0x7E therefore come through intact.
- R3: Seven or more consecutive 1s inside a frame abort it. The frame is not delivered, `abort_seen` goes to 1, and the receiver resumes at the next flag.
- R4: With `fcs_off`=0, a frame passes only when the reflected CRC-CCITT (initial value 0xFFFF) over its bytes, FCS included, gives the residue 0xF0B8. A passing frame is delivered with its two FCS bytes stripped. A failing frame sets `fcs_err`, is not delivered, and leaves the buffer and `msg_len` unchanged.
- R5: With `fcs_off`=1, no check is made. All bytes between the flags are delivered and `fcs_err` never rises.
- R6: Frames are dropped without any status change when they have fewer than 4 bytes between flags, do not hold a whole number of bytes, or hold more than DEPTH bytes.
- R7: With `dup_drop_en`=1, a completed frame or codeword message whose length and bytes equal the buffer contents is dropped. `msg_ready` stays 0 and the buffer is unchanged.
- R8: With `dup_drop_en`=0, every completed message is delivered, identical ones included.
- R9: A codeword is eight 1s followed by eight bits whose first and last bits are 0 (the value 0x7E is excluded). When the same codeword arrives in BOS_REPS back-to-back 16-bit repetitions, a one-byte message holding the codeword byte (first bit in bit 0) is produced, once per run, with `msg_is_bos`=1. Frame messages give `msg_is_bos`=0. A single repetition produces nothing.
- R10: After reset, `msg_ready`, `fcs_err`, `abort_seen` and `msg_len` are 0. Each flag stays set until a one-cycle `ack` clears it. A new event in the same cycle wins over `ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies `bit_in` for one clock |
| bit_in | input | 1 | Serial line bit |
| fcs_off | input | 1 | 1 skips the FCS check and keeps the FCS bytes |
| dup_drop_en | input | 1 | 1 drops messages identical to the buffer |
| rd_addr | input | $clog2(DEPTH) | Buffer byte address |
| rd_data | output | 8 | Buffer byte at `rd_addr` |
| msg_len | output | $clog2(DEPTH+1) | Length of the buffered message |
| msg_ready | output | 1 | New message in the buffer |
| msg_is_bos | output | 1 | Buffered message came from a codeword |
| ack | input | 1 | One-cycle strobe clearing the status flags |
| fcs_err | output | 1 | A frame failed the FCS check |
| abort_seen | output | 1 | A frame was aborted |

## Verification
The hardest case to reach is a repeat that must be recognised. The stored copy has to be a message that was really delivered, and the second copy must arrive complete, with a valid FCS and under the same suppression setting. For codewords, the two copies must also land exactly one period apart. The bench re-sends the frame it just had delivered, then flips one byte to show the comparison is sensitive. It sends codeword runs of one, two and three repetitions, separated by runs of zeros, so that continuation, a fresh run and a lone repetition each occur. A random phase mixes repeats and new frames while suppression is on.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
   localparam logic [7:0]  FLAG_BYTE = 8'h7E;
   localparam logic [15:0] CRC_SEED  = 16'hFFFF;
   localparam logic [15:0] CRC_GOOD  = 16'hF0B8;
   localparam logic [15:0] CRC_POLY  = 16'h8408;

   function automatic logic [15:0] crc16_byte(input logic [15:0] c_in, input logic [7:0] b);
      logic [15:0] c;
      c = c_in;
      for (int i = 0; i < 8; i++) begin
         if ((c[0] ^ b[i]) == 1'b1) c = (c >> 1) ^ CRC_POLY;
         else                       c = c >> 1;
      end
      return c;
   endfunction
endpackage

// File: rtl/hdlc_bit_deframer.sv
module hdlc_bit_deframer
   import hdlc_rx_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int MIN_BYTES = 4,
   localparam int AW = $clog2(DEPTH),
   localparam int LW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_en,
   input  logic          bit_in,
   output logic          byte_we,
   output logic [AW-1:0] byte_idx,
   output logic [7:0]    byte_data,
   output logic          frame_done,
   output logic [LW-1:0] done_len,
   output logic          done_crc_ok,
   output logic          abort_pulse
);
   logic [2:0]    ones;
   logic          in_frame;
   logic [2:0]    bitcnt;
   logic [7:0]    sr;
   logic [LW-1:0] nbytes;
   logic          ovf;
   logic [15:0]   crc;
   logic [7:0]    sr_next;

   assign sr_next = {bit_in, sr[7:1]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ones <= '0; in_frame <= 1'b0; bitcnt <= '0; sr <= '0; nbytes <= '0;
         ovf <= 1'b0; crc <= CRC_SEED; byte_we <= 1'b0; byte_idx <= '0;
         byte_data <= '0; frame_done <= 1'b0; done_len <= '0;
         done_crc_ok <= 1'b0; abort_pulse <= 1'b0;
      end else begin
         byte_we     <= 1'b0;
         frame_done  <= 1'b0;
         abort_pulse <= 1'b0;
         if (bit_en) begin
            if (bit_in) ones <= (ones == 3'd7) ? 3'd7 : ones + 3'd1;
            else        ones <= '0;
            if (bit_in && ones == 3'd6) begin
               if (in_frame) begin
                  abort_pulse <= 1'b1;
                  in_frame    <= 1'b0;
               end
            end else if (!bit_in && ones == 3'd6) begin
               if (in_frame && bitcnt == 3'd6 && nbytes >= LW'(MIN_BYTES) && !ovf) begin
                  frame_done  <= 1'b1;
                  done_len    <= nbytes;
                  done_crc_ok <= (crc == CRC_GOOD);
               end
               in_frame <= 1'b1;
               bitcnt   <= '0;
               nbytes   <= '0;
               ovf      <= 1'b0;
               crc      <= CRC_SEED;
            end else if (!bit_in && ones == 3'd5) begin
               // stuffed zero: dropped
            end else if (bit_in && ones >= 3'd5) begin
               // sixth and later ones belong to a flag or abort
            end else if (in_frame) begin
               sr     <= sr_next;
               bitcnt <= bitcnt + 3'd1;
               if (bitcnt == 3'd7) begin
                  if (nbytes == LW'(DEPTH)) begin
                     ovf <= 1'b1;
                  end else begin
                     byte_we   <= 1'b1;
                     byte_idx  <= nbytes[AW-1:0];
                     byte_data <= sr_next;
                     nbytes    <= nbytes + LW'(1);
                     crc       <= crc16_byte(crc, sr_next);
                  end
               end
            end
         end
      end
   end

   assert_stuff_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && in_frame && ones == 3'd5 && !bit_in) |=> $stable(bitcnt) && !byte_we);

   assert_abort_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && bit_in && ones == 3'd6 && in_frame) |=> (!in_frame && abort_pulse && !frame_done));
endmodule

// File: rtl/hdlc_bos_watch.sv
module hdlc_bos_watch #(
   parameter int BOS_REPS = 2,
   localparam int RW = $clog2(BOS_REPS + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic       bit_in,
   output logic       bos_hit,
   output logic [7:0] bos_code
);
   localparam int PERIOD = 16;

   logic [15:0]   raw;
   logic [15:0]   raw_next;
   logic [4:0]    gap;
   logic [RW-1:0] reps;
   logic [7:0]    prev_code;
   logic          match;
   logic          back_to_back;

   assign raw_next     = {bit_in, raw[15:1]};
   assign match        = (raw_next[7:0] == 8'hFF) && !raw_next[8] && !raw_next[15]
                         && (raw_next[15:8] != 8'h7E);
   assign back_to_back = (reps != '0) && (gap == 5'(PERIOD - 1)) && (raw_next[15:8] == prev_code);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw <= '0; gap <= '1; reps <= '0; prev_code <= '0;
         bos_hit <= 1'b0; bos_code <= '0;
      end else begin
         bos_hit <= 1'b0;
         if (bit_en) begin
            raw <= raw_next;
            if (match) begin
               gap       <= '0;
               prev_code <= raw_next[15:8];
               if (back_to_back) begin
                  if (reps == RW'(BOS_REPS - 1)) begin
                     bos_hit  <= 1'b1;
                     bos_code <= raw_next[15:8];
                  end
                  if (reps != RW'(BOS_REPS)) reps <= reps + RW'(1);
               end else begin
                  reps <= RW'(1);
               end
            end else if (gap != '1) begin
               gap <= gap + 5'd1;
            end
         end
      end
   end

   assert_hit_framing_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bos_hit |-> (!bos_code[0] && !bos_code[7] && raw[7:0] == 8'hFF));
endmodule

// File: rtl/hdlc_buf_compare.sv
module hdlc_buf_compare #(
   parameter int DEPTH = 32,
   localparam int LW = $clog2(DEPTH + 1)
) (
   input  logic [DEPTH-1:0][7:0] new_buf,
   input  logic [LW-1:0]         new_len,
   input  logic [DEPTH-1:0][7:0] old_buf,
   input  logic [LW-1:0]         old_len,
   output logic                  same
);
   logic [DEPTH-1:0] diff;

   for (genvar g = 0; g < DEPTH; g++) begin : g_byte
      assign diff[g] = (new_len > LW'(g)) && (new_buf[g] != old_buf[g]);
   end

   assign same = (new_len == old_len) && (diff == '0);
endmodule

// File: rtl/hdlc_dup_rx.sv
module hdlc_dup_rx #(
   parameter int DEPTH = 32,
   parameter int BOS_REPS = 2,
   localparam int AW = $clog2(DEPTH),
   localparam int LW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_en,
   input  logic          bit_in,
   input  logic          fcs_off,
   input  logic          dup_drop_en,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data,
   output logic [LW-1:0] msg_len,
   output logic          msg_ready,
   output logic          msg_is_bos,
   input  logic          ack,
   output logic          fcs_err,
   output logic          abort_seen
);
   if (DEPTH < 4 || DEPTH > 256) begin : g_bad_depth
      $error("hdlc_dup_rx: DEPTH must lie in 4..256");
   end
   if (BOS_REPS < 2 || BOS_REPS > 8) begin : g_bad_reps
      $error("hdlc_dup_rx: BOS_REPS must lie in 2..8");
   end

   logic          byte_we;
   logic [AW-1:0] byte_idx;
   logic [7:0]    byte_data;
   logic          frame_done;
   logic [LW-1:0] done_len;
   logic          done_crc_ok;
   logic          abort_pulse;
   logic          bos_hit;
   logic [7:0]    bos_code;

   logic [DEPTH-1:0][7:0] shadow;
   logic [DEPTH-1:0][7:0] stored;
   logic                  pending;
   logic [LW-1:0]         cand_len;
   logic                  cand_bos;
   logic                  same;
   logic                  commit;

   hdlc_bit_deframer #(.DEPTH(DEPTH)) i_deframer (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
      .byte_we(byte_we), .byte_idx(byte_idx), .byte_data(byte_data),
      .frame_done(frame_done), .done_len(done_len), .done_crc_ok(done_crc_ok),
      .abort_pulse(abort_pulse)
   );

   hdlc_bos_watch #(.BOS_REPS(BOS_REPS)) i_bos (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
      .bos_hit(bos_hit), .bos_code(bos_code)
   );

   hdlc_buf_compare #(.DEPTH(DEPTH)) i_cmp (
      .new_buf(shadow), .new_len(cand_len), .old_buf(stored), .old_len(msg_len),
      .same(same)
   );

   assign commit  = pending && !(dup_drop_en && same);
   assign rd_data = (int'(rd_addr) < DEPTH) ? stored[rd_addr] : 8'h00;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow <= '0;
      end else if (bos_hit) begin
         shadow[0] <= bos_code;
      end else if (byte_we) begin
         shadow[byte_idx] <= byte_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending <= 1'b0; cand_len <= '0; cand_bos <= 1'b0;
         stored <= '0; msg_len <= '0; msg_is_bos <= 1'b0;
         msg_ready <= 1'b0; fcs_err <= 1'b0; abort_seen <= 1'b0;
      end else begin
         pending <= 1'b0;
         if (bos_hit) begin
            pending  <= 1'b1;
            cand_len <= LW'(1);
            cand_bos <= 1'b1;
         end else if (frame_done) begin
            if (!fcs_off && !done_crc_ok) begin
               fcs_err <= 1'b1;
            end else begin
               pending  <= 1'b1;
               cand_len <= fcs_off ? done_len : done_len - LW'(2);
               cand_bos <= 1'b0;
            end
         end
         if (!(frame_done && !bos_hit && !fcs_off && !done_crc_ok) && ack) fcs_err <= 1'b0;

         if (commit) begin
            stored     <= shadow;
            msg_len    <= cand_len;
            msg_is_bos <= cand_bos;
            msg_ready  <= 1'b1;
         end else if (ack) begin
            msg_ready <= 1'b0;
         end

         if (abort_pulse)  abort_seen <= 1'b1;
         else if (ack)     abort_seen <= 1'b0;
      end
   end

   assert_fcs_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !bos_hit && !fcs_off && !done_crc_ok) |=> (fcs_err && !pending));

   assert_fcs_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fcs_off && !fcs_err) |=> !fcs_err);

   assert_dup_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && dup_drop_en && same && !ack) |=> ($stable(msg_ready) && $stable(msg_len)));

   assert_bos_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bos_hit |=> (pending && cand_len == LW'(1) && cand_bos));

   assert_ready_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_ready && !ack) |=> msg_ready);

   assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !pending) |=> !msg_ready);
endmodule

// File: tb/test_hdlc_dup_rx.sv
module test_hdlc_dup_rx;
   localparam int DEPTH = 32;
   localparam int AW = $clog2(DEPTH);
   localparam int LW = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bit_en = 1'b0;
   logic          bit_in = 1'b0;
   logic          fcs_off = 1'b0;
   logic          dup_drop_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_data;
   logic [LW-1:0] msg_len;
   logic          msg_ready;
   logic          msg_is_bos;
   logic          ack = 1'b0;
   logic          fcs_err;
   logic          abort_seen;

   int errors = 0;
   int checks = 0;
   int tx_ones = 0;
   logic [7:0] fb [0:39];
   int fn = 0;

   always #4 clk = ~clk;

   hdlc_dup_rx #(.DEPTH(DEPTH), .BOS_REPS(2)) i_hdlc_dup_rx (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
      .fcs_off(fcs_off), .dup_drop_en(dup_drop_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .msg_len(msg_len), .msg_ready(msg_ready),
      .msg_is_bos(msg_is_bos), .ack(ack), .fcs_err(fcs_err), .abort_seen(abort_seen)
   );

   function automatic logic [15:0] crc_step(input logic [15:0] c_in, input logic [7:0] b);
      logic [15:0] c;
      c = c_in;
      for (int i = 0; i < 8; i++) begin
         if ((c[0] ^ b[i]) == 1'b1) c = (c >> 1) ^ 16'h8408;
         else                       c = c >> 1;
      end
      return c;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put_bit(input logic b);
      @(negedge clk);
      bit_en = 1'b1;
      bit_in = b;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bit_en = 1'b0;
      end
   endtask

   task automatic put_flag();
      for (int i = 0; i < 8; i++) put_bit(i != 0 && i != 7);
   endtask

   task automatic put_byte(input logic [7:0] b);
      for (int i = 0; i < 8; i++) begin
         put_bit(b[i]);
         if (b[i]) tx_ones++; else tx_ones = 0;
         if (tx_ones == 5) begin
            put_bit(1'b0);
            tx_ones = 0;
         end
      end
   endtask

   task automatic send_frame(input bit with_fcs, input bit corrupt);
      logic [15:0] c;
      c = 16'hFFFF;
      for (int i = 0; i < fn; i++) c = crc_step(c, fb[i]);
      c = ~c;
      if (corrupt) c = c ^ 16'h0001;
      put_flag();
      tx_ones = 0;
      for (int i = 0; i < fn; i++) put_byte(fb[i]);
      if (with_fcs) begin
         put_byte(c[7:0]);
         put_byte(c[15:8]);
      end
      put_flag();
      idle(6);
   endtask

   task automatic put_bos(input logic [7:0] code, input int reps);
      for (int r = 0; r < reps; r++) begin
         for (int i = 0; i < 8; i++) put_bit(1'b1);
         for (int i = 0; i < 8; i++) put_bit(code[i]);
      end
      idle(6);
   endtask

   task automatic put_zeros(input int n);
      for (int i = 0; i < n; i++) put_bit(1'b0);
      idle(2);
   endtask

   task automatic fill_rand(input int n);
      fn = n;
      for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
   endtask

   task automatic do_ack();
      @(negedge clk) ack = 1'b1;
      @(negedge clk) ack = 1'b0;
   endtask

   task automatic expect_msg(input string req, input int elen);
      int bad;
      bad = 0;
      chk(msg_ready == 1'b1, req, msg_ready, 1);
      chk(int'(msg_len) == elen, req, msg_len, elen);
      for (int i = 0; i < elen; i++) begin
         rd_addr = AW'(i);
         #1;
         if (rd_data != fb[i]) begin
            if (bad == 0) $display("FAIL %s byte %0d actual=%0h expected=%0h", req, i, rd_data, fb[i]);
            bad++;
         end
      end
      checks++;
      if (bad != 0) errors++;
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int old_len;
      void'($urandom(32'h5EED_1234));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(msg_ready == 1'b0, "R10 reset ready", msg_ready, 0);
      chk(fcs_err == 1'b0, "R10 reset fcs_err", fcs_err, 0);
      chk(abort_seen == 1'b0, "R10 reset abort", abort_seen, 0);
      chk(msg_len == '0, "R10 reset len", msg_len, 0);

      // R1 R2 R4: stuffing-heavy payload with good FCS
      fn = 6;
      fb[0] = 8'hFF; fb[1] = 8'h7E; fb[2] = 8'h3E; fb[3] = 8'h1F; fb[4] = 8'hFC; fb[5] = 8'hFF;
      send_frame(1'b1, 1'b0);
      expect_msg("R2 stuffed payload", 6);
      chk(msg_is_bos == 1'b0, "R9 frame not bos", msg_is_bos, 0);
      do_ack();
      chk(msg_ready == 1'b0, "R10 ack clears", msg_ready, 0);

      // R1 R4 random frames
      for (int k = 0; k < 8; k++) begin
         fill_rand(2 + int'($urandom % 10));
         send_frame(1'b1, 1'b0);
         expect_msg("R1 random frame", fn);
         do_ack();
      end

      // R4 bad FCS
      old_len = int'(msg_len);
      fill_rand(5);
      send_frame(1'b1, 1'b1);
      chk(fcs_err == 1'b1, "R4 fcs_err set", fcs_err, 1);
      chk(msg_ready == 1'b0, "R4 bad frame not ready", msg_ready, 0);
      chk(int'(msg_len) == old_len, "R4 buffer kept", msg_len, old_len);
      idle(3);
      chk(fcs_err == 1'b1, "R10 fcs_err sticky", fcs_err, 1);
      do_ack();
      chk(fcs_err == 1'b0, "R10 fcs_err cleared", fcs_err, 0);

      // R5 check disabled
      fcs_off = 1'b1;
      fill_rand(5);
      send_frame(1'b0, 1'b0);
      expect_msg("R5 unchecked frame", 5);
      chk(fcs_err == 1'b0, "R5 no fcs_err", fcs_err, 0);
      do_ack();

      // R6 short, partial, oversize
      old_len = int'(msg_len);
      fill_rand(3);
      send_frame(1'b0, 1'b0);
      chk(msg_ready == 1'b0, "R6 short dropped", msg_ready, 0);
      put_flag();
      for (int i = 0; i < 12; i++) put_bit(i[0]);
      put_flag();
      idle(6);
      chk(msg_ready == 1'b0, "R6 partial dropped", msg_ready, 0);
      fill_rand(34);
      send_frame(1'b0, 1'b0);
      chk(msg_ready == 1'b0, "R6 oversize dropped", msg_ready, 0);
      chk(int'(msg_len) == old_len, "R6 buffer kept", msg_len, old_len);
      fcs_off = 1'b0;

      // R3 abort
      fill_rand(4);
      put_flag();
      tx_ones = 0;
      for (int i = 0; i < 4; i++) put_byte(fb[i]);
      for (int i = 0; i < 8; i++) put_bit(1'b1);
      put_flag();
      idle(6);
      chk(abort_seen == 1'b1, "R3 abort flagged", abort_seen, 1);
      chk(msg_ready == 1'b0, "R3 aborted not ready", msg_ready, 0);
      do_ack();
      chk(abort_seen == 1'b0, "R10 abort cleared", abort_seen, 0);
      fill_rand(3);
      send_frame(1'b1, 1'b0);
      expect_msg("R3 recovery frame", 3);
      do_ack();

      // R7 R8 repeat suppression
      dup_drop_en = 1'b1;
      send_frame(1'b1, 1'b0);
      chk(msg_ready == 1'b0, "R7 repeat dropped", msg_ready, 0);
      expect_msg_silent: begin
         chk(int'(msg_len) == 3, "R7 buffer kept", msg_len, 3);
      end
      fb[1] = fb[1] ^ 8'h10;
      send_frame(1'b1, 1'b0);
      expect_msg("R7 changed byte delivered", 3);
      do_ack();
      dup_drop_en = 1'b0;
      send_frame(1'b1, 1'b0);
      expect_msg("R8 repeat delivered", 3);
      do_ack();

      // R9 codewords
      dup_drop_en = 1'b1;
      put_bos(8'h24, 3);
      fn = 1; fb[0] = 8'h24;
      expect_msg("R9 codeword message", 1);
      chk(msg_is_bos == 1'b1, "R9 bos marker", msg_is_bos, 1);
      do_ack();
      put_zeros(20);
      put_bos(8'h24, 3);
      chk(msg_ready == 1'b0, "R7 codeword repeat dropped", msg_ready, 0);
      put_zeros(20);
      put_bos(8'h42, 1);
      chk(msg_ready == 1'b0, "R9 single repetition ignored", msg_ready, 0);
      put_zeros(20);
      put_bos(8'h42, 2);
      fb[0] = 8'h42;
      expect_msg("R9 new codeword", 1);
      do_ack();
      fill_rand(4);
      send_frame(1'b1, 1'b0);
      expect_msg("R9 frame after codeword", 4);
      chk(msg_is_bos == 1'b0, "R9 marker cleared", msg_is_bos, 0);
      do_ack();

      // R7 random mix of repeats and fresh frames
      for (int k = 0; k < 8; k++) begin
         bit rep;
         rep = ($urandom % 2) == 1;
         if (!rep) fill_rand(2 + int'($urandom % 8));
         send_frame(1'b1, 1'b0);
         if (rep) chk(msg_ready == 1'b0, "R7 random repeat", msg_ready, 0);
         else     expect_msg("R7 random fresh", fn);
         do_ack();
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule